// File: doc/BRIEF.md
# Boot Strap Mode Selector

This block decides how a chip boots. Two strap inputs are read once, as reset is released, and give one of four boot modes. Three of them are coprocessor modes, each tied to one host interface: a parallel host port, a high-speed serial link or an SPI slave. The fourth is a standalone mode that boots from an I2C EEPROM. After release the block holds a boot-busy window of `BOOT_CYC` clock cycles, then raises boot-done. Only then does it drive its results: a one-hot interface enable, a direction and function code for each pin of a small GPIO bank, and a host or peripheral role for each USB port.

In a coprocessor mode only the selected interface is enabled and every GPIO pin, the strap pins included, is a plain input. In standalone mode the pins just below the top of the bank take on fixed functions:

- the two strap pins drive the EEPROM;
- the next two pins form a debug UART;
- the pin after those reads the OTG ID.

The OTG ID pin sets the role of USB port 0 continuously after boot. The remaining USB ports are peripherals.

Top module: `boot_strap_sel`

## Requirements
- R1: After boot-done, `mode_o` equals the captured strap value {upper, lower} and `if_en_o` has exactly bit `mode_o` set. The bit meanings are: 0 parallel host port, 1 high-speed serial, 2 SPI slave, 3 standalone I2C EEPROM.
- R2: The straps pass through a two-flop synchronizer and are captured on the first rising edge after `rst_n` deasserts. Strap changes made after release do not alter `mode_o`.
- R3: `boot_done_o` rises on rising edge `BOOT_CYC+1` after `rst_n` deasserts and then stays high until reset. `boot_busy_o` is always its complement.
- R4: While `boot_done_o` is low, `mode_o`, `if_en_o`, `pin_oe_o`, `pin_func_o` and `usb_role_o` are all zero. This means every pin is an input with function code 0.
- R5: In modes 00, 01 and 10 after boot, every pin has `pin_oe_o`=0 and function code 0 (general GPIO), and `usb_role_o` is zero.
- R6: In mode 11 after boot, pins `GPIO_W-1` and `GPIO_W-2` are outputs with function code 1 (EEPROM).
- R7: In mode 11 after boot, pins `GPIO_W-3` (transmit, output) and `GPIO_W-4` (receive, input) carry function code 2 (debug UART).
- R8: In mode 11 after boot, pin `GPIO_W-5` is an input with function code 3 (OTG ID). `usb_role_o[0]` equals the OTG ID input delayed by two rising edges, where 1 means peripheral and 0 means host.
- R9: In mode 11 after boot, `usb_role_o[USB_PORTS-1:1]` are all 1 (peripheral). All pins below `GPIO_W-5` are inputs with function code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; its release starts boot |
| strap_i | input | 2 | Boot strap pins, [1] upper, [0] lower |
| otg_id_i | input | 1 | OTG ID pin level |
| boot_busy_o | output | 1 | Boot window in progress |
| boot_done_o | output | 1 | Boot complete, outputs valid |
| mode_o | output | 2 | Captured boot mode |
| if_en_o | output | 4 | One-hot host interface enable |
| pin_oe_o | output | GPIO_W | Per-pin output enable (1 = output) |
| pin_func_o | output | 2*GPIO_W | Per-pin function code, pin i at [2i+1:2i] |
| usb_role_o | output | USB_PORTS | Per-port role, 1 = peripheral, 0 = host |

## Verification
The assertions watch, on every cycle, the relations that hold at any time:
- busy is always the complement of done;
- done never falls;
- the outputs keep their safe value before done;
- the mode is frozen once done is high;
- the interface enable stays one-hot and agrees with the mode;
- the non-OTG USB ports read peripheral in standalone mode.

Other behaviour depends on what happened at the inputs in earlier cycles, so only the bench scenarios can show it:
- the exact cycle on which done rises;
- that the value captured is the strap level at release and not a later one;
- the complete pin map for each mode;
- the two-edge lag of the USB role behind the ID pin.

// File: rtl/bss_pkg.sv
package bss_pkg;
   typedef enum logic [1:0] {
      BM_PARALLEL = 2'b00,
      BM_HSSERIAL = 2'b01,
      BM_SPISLAVE = 2'b10,
      BM_STANDALN = 2'b11
   } boot_mode_e;

   typedef enum logic [1:0] {
      ST_CAPTURE,
      ST_WINDOW,
      ST_READY
   } boot_state_e;

   localparam logic [1:0] FN_GPIO   = 2'd0;
   localparam logic [1:0] FN_EEPROM = 2'd1;
   localparam logic [1:0] FN_UART   = 2'd2;
   localparam logic [1:0] FN_OTGID  = 2'd3;

   localparam int NUM_IF = 4;
endpackage

// File: rtl/bss_sync.sv
module bss_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("bss_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      chain[0] <= d_i;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bss_seq.sv
module bss_seq
   import bss_pkg::*;
#(
   parameter int BOOT_CYC = 750000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] strap_s_i,
   output logic [1:0] mode_q_o,
   output logic       done_o
);
   localparam int CW = (BOOT_CYC < 2) ? 1 : $clog2(BOOT_CYC);
   localparam logic [CW-1:0] LAST = CW'(BOOT_CYC - 1);

   if (BOOT_CYC < 1) begin : g_bad_cyc
      $error("bss_seq: BOOT_CYC must be at least 1");
   end

   boot_state_e      state;
   logic [CW-1:0]    cnt;
   logic [1:0]       mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_CAPTURE;
         cnt    <= '0;
         mode_q <= '0;
      end else begin
         unique case (state)
            ST_CAPTURE: begin
               mode_q <= strap_s_i;
               cnt    <= '0;
               state  <= ST_WINDOW;
            end
            ST_WINDOW: begin
               if (cnt == LAST) begin
                  state <= ST_READY;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_READY;
         endcase
      end
   end

   assign mode_q_o = mode_q;
   assign done_o   = (state == ST_READY);
endmodule

// File: rtl/bss_pinmap.sv
module bss_pinmap
   import bss_pkg::*;
#(
   parameter int GPIO_W    = 8,
   parameter int USB_PORTS = 4
) (
   input  logic                  done_i,
   input  logic [1:0]            mode_i,
   input  logic                  otg_id_s_i,
   output logic [NUM_IF-1:0]     if_en_o,
   output logic [GPIO_W-1:0]     pin_oe_o,
   output logic [2*GPIO_W-1:0]   pin_func_o,
   output logic [USB_PORTS-1:0]  usb_role_o
);
   localparam int P_EE_HI = GPIO_W - 1;
   localparam int P_EE_LO = GPIO_W - 2;
   localparam int P_TX    = GPIO_W - 3;
   localparam int P_RX    = GPIO_W - 4;
   localparam int P_ID    = GPIO_W - 5;

   logic standalone;
   assign standalone = done_i && (mode_i == BM_STANDALN);

   for (genvar k = 0; k < NUM_IF; k++) begin : g_ifen
      assign if_en_o[k] = done_i && (mode_i == 2'(k));
   end

   for (genvar i = 0; i < GPIO_W; i++) begin : g_pin
      if (i == P_EE_HI || i == P_EE_LO) begin : g_ee
         assign pin_oe_o[i]        = standalone;
         assign pin_func_o[2*i+:2] = standalone ? FN_EEPROM : FN_GPIO;
      end else if (i == P_TX) begin : g_tx
         assign pin_oe_o[i]        = standalone;
         assign pin_func_o[2*i+:2] = standalone ? FN_UART : FN_GPIO;
      end else if (i == P_RX) begin : g_rx
         assign pin_oe_o[i]        = 1'b0;
         assign pin_func_o[2*i+:2] = standalone ? FN_UART : FN_GPIO;
      end else if (i == P_ID) begin : g_id
         assign pin_oe_o[i]        = 1'b0;
         assign pin_func_o[2*i+:2] = standalone ? FN_OTGID : FN_GPIO;
      end else begin : g_gp
         assign pin_oe_o[i]        = 1'b0;
         assign pin_func_o[2*i+:2] = FN_GPIO;
      end
   end

   for (genvar u = 0; u < USB_PORTS; u++) begin : g_usb
      if (u == 0) begin : g_otg
         assign usb_role_o[u] = standalone && otg_id_s_i;
      end else begin : g_fixed
         assign usb_role_o[u] = standalone;
      end
   end
endmodule

// File: rtl/boot_strap_sel.sv
module boot_strap_sel
   import bss_pkg::*;
#(
   parameter int GPIO_W      = 8,
   parameter int USB_PORTS   = 4,
   parameter int BOOT_CYC    = 750000,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            strap_i,
   input  logic                  otg_id_i,
   output logic                  boot_busy_o,
   output logic                  boot_done_o,
   output logic [1:0]            mode_o,
   output logic [3:0]            if_en_o,
   output logic [GPIO_W-1:0]     pin_oe_o,
   output logic [2*GPIO_W-1:0]   pin_func_o,
   output logic [USB_PORTS-1:0]  usb_role_o
);
   if (GPIO_W < 5) begin : g_bad_w
      $error("boot_strap_sel: GPIO_W must be at least 5");
   end
   if (USB_PORTS < 1) begin : g_bad_usb
      $error("boot_strap_sel: USB_PORTS must be at least 1");
   end

   logic [1:0] strap_s;
   logic       otg_id_s;
   logic [1:0] mode_q;
   logic       done;

   bss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_strap_sync (
      .clk (clk),
      .d_i (strap_i),
      .q_o (strap_s)
   );

   bss_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_id_sync (
      .clk (clk),
      .d_i (otg_id_i),
      .q_o (otg_id_s)
   );

   bss_seq #(.BOOT_CYC(BOOT_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap_s_i (strap_s),
      .mode_q_o  (mode_q),
      .done_o    (done)
   );

   bss_pinmap #(.GPIO_W(GPIO_W), .USB_PORTS(USB_PORTS)) u_map (
      .done_i     (done),
      .mode_i     (mode_q),
      .otg_id_s_i (otg_id_s),
      .if_en_o    (if_en_o),
      .pin_oe_o   (pin_oe_o),
      .pin_func_o (pin_func_o),
      .usb_role_o (usb_role_o)
   );

   assign boot_done_o = done;
   assign boot_busy_o = ~done;
   assign mode_o      = done ? mode_q : 2'b00;
endmodule

// File: rtl/boot_strap_chk.sv
module boot_strap_chk #(
   parameter int GPIO_W    = 8,
   parameter int USB_PORTS = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  boot_busy_o,
   input logic                  boot_done_o,
   input logic [1:0]            mode_o,
   input logic [3:0]            if_en_o,
   input logic [GPIO_W-1:0]     pin_oe_o,
   input logic [2*GPIO_W-1:0]   pin_func_o,
   input logic [USB_PORTS-1:0]  usb_role_o
);
   p_busy_cpl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      boot_busy_o != boot_done_o);

   p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done_o |=> boot_done_o);

   p_safe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !boot_done_o |-> (if_en_o == '0 && pin_oe_o == '0 && pin_func_o == '0
                        && usb_role_o == '0 && mode_o == '0));

   p_mode_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done_o && $past(boot_done_o)) |-> $stable(mode_o));

   p_ifen_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done_o |-> ($countones(if_en_o) == 1 && if_en_o[mode_o]));

   p_copro_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done_o && mode_o != 2'b11) |-> (pin_oe_o == '0 && usb_role_o == '0));

   p_ports_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_done_o && mode_o == 2'b11) |-> (usb_role_o >> 1) == ({USB_PORTS{1'b1}} >> 1));
endmodule

bind boot_strap_sel boot_strap_chk #(.GPIO_W(GPIO_W), .USB_PORTS(USB_PORTS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .boot_busy_o (boot_busy_o),
   .boot_done_o (boot_done_o),
   .mode_o      (mode_o),
   .if_en_o     (if_en_o),
   .pin_oe_o    (pin_oe_o),
   .pin_func_o  (pin_func_o),
   .usb_role_o  (usb_role_o)
);

// File: tb/sim_boot_strap_sel.sv
`timescale 1ns/1ps
module sim_boot_strap_sel;
   localparam int W  = 8;
   localparam int U  = 4;
   localparam int BC = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    strap = 2'b00;
   logic          otg_id = 1'b0;
   logic          busy, done;
   logic [1:0]    mode;
   logic [3:0]    if_en;
   logic [W-1:0]  oe;
   logic [2*W-1:0] func;
   logic [U-1:0]  role;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   boot_strap_sel #(.GPIO_W(W), .USB_PORTS(U), .BOOT_CYC(BC)) u0 (
      .clk(clk), .rst_n(rst_n), .strap_i(strap), .otg_id_i(otg_id),
      .boot_busy_o(busy), .boot_done_o(done), .mode_o(mode), .if_en_o(if_en),
      .pin_oe_o(oe), .pin_func_o(func), .usb_role_o(role));

   function automatic logic [W-1:0] e_oe(input logic [1:0] m);
      return (m == 2'b11) ? 8'b1110_0000 : 8'h00;
   endfunction

   function automatic logic [2*W-1:0] e_func(input logic [1:0] m);
      return (m == 2'b11) ? 16'h5AC0 : 16'h0000;
   endfunction

   function automatic logic [U-1:0] e_role(input logic [1:0] m, input logic id);
      return (m == 2'b11) ? {3'b111, id} : 4'b0000;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic boot(input logic [1:0] s, input logic id, input logic [1:0] s_late);
      rst_n  = 1'b0;
      strap  = s;
      otg_id = id;
      repeat (4) @(negedge clk);
      chk(!done && busy, "R3 reset", {busy, done}, 2'b10);
      rst_n = 1'b1;
      strap = s_late;
      repeat (BC) @(negedge clk);
      chk(!done && busy, "R3 not yet done", {busy, done}, 2'b10);
      chk(if_en == 0 && oe == 0 && func == 0 && role == 0 && mode == 0,
          "R4 safe before done", {if_en, oe, func, role, mode}, 0);
      @(negedge clk);
      chk(done && !busy, "R3 done edge", {busy, done}, 2'b01);
      chk(mode == s, "R1/R2 mode", mode, s);
      chk(if_en == (4'b0001 << s), "R1 if_en", if_en, 4'b0001 << s);
      chk(oe == e_oe(s), (s == 2'b11) ? "R6/R7 pin_oe" : "R5 pin_oe", oe, e_oe(s));
      chk(func == e_func(s), (s == 2'b11) ? "R6/R7/R8/R9 pin_func" : "R5 pin_func",
          func, e_func(s));
      chk(role == e_role(s, id), (s == 2'b11) ? "R8/R9 usb_role" : "R5 usb_role",
          role, e_role(s, id));
      otg_id = ~id;
      @(negedge clk);
      chk(role == e_role(s, id), "R8 role one edge", role, e_role(s, id));
      @(negedge clk);
      chk(role == e_role(s, ~id), "R8 role two edges", role, e_role(s, ~id));
      strap = ~s;
      repeat (3) @(negedge clk);
      chk(mode == s && done, "R2 late strap ignored", mode, s);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int m = 0; m < 4; m++) begin
         boot(2'(m), 1'b0, ~2'(m));
         boot(2'(m), 1'b1, 2'(m));
      end
      for (int n = 0; n < 12; n++) begin
         boot(2'($urandom), 1'($urandom), 2'($urandom));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule